// File: doc/BRIEF.md
# Conditional Select and Compare Unit

This unit tests a four-bit condition code against the current N, Z, C and V flags. It then does one of two things. The select operations pick between two operands, and when the condition fails they can instead return the second operand incremented, inverted or negated. The conditional compares run a subtraction or an addition when the condition holds and produce new flags. When the condition fails, they load a literal four-bit flag value in place of those flags.

An execute stage drives one operation per clock. The result and the next flags come out of a single register stage one cycle later. Set-on-condition and set-mask are not separate operations. They are obtained by feeding zero operands to select-increment or select-invert with the condition code's low bit flipped. The `wide` input chooses 64-bit or 32-bit width. In 32-bit mode the upper half of the result is zero and the flags come from a 32-bit computation.

Top module: `cond_sel_unit`

## Requirements
- R1: Flags are packed as flags_in[3]=N, [2]=Z, [1]=C, [0]=V. Condition codes 0..15 mean Z, !Z, C, !C, N, !N, V, !V, C&!Z, !C|Z, N==V, N!=V, !Z&(N==V), Z|(N!=V), true, true.
- R2: op_sel 000 (select) returns opa when the condition holds, else opb.
- R3: op_sel 001 (select-increment) returns opa when the condition holds, else opb+1.
- R4: op_sel 010 (select-invert) returns opa when the condition holds, else ~opb.
- R5: op_sel 011 (select-negate) returns opa when the condition holds, else the two's-complement negation of opb.
- R6: op_sel 100 (compare) with the condition true sets N, Z, C and V from opa minus the second operand, using add-with-carry rules (C=1 means no borrow). The second operand is opb, or imm5 zero-extended when use_imm=1.
- R7: op_sel 101 (compare-negative) with the condition true sets the flags from opa plus the second operand, chosen the same way as in R6.
- R8: For op_sel 100 or 101 with the condition false, flags_out becomes fallback.
- R9: The select operations pass flags_in unchanged to flags_out. Both compare operations output a result of zero.
- R10: With wide=0, result[63:32] is zero and the result and flags are computed on the low 32 bits. Signed overflow and carry are taken at bit 31.
- R11: op_sel 110 and 111 behave as plain select.
- R12: Outputs are registered with a latency of one cycle. An active-low reset clears result and flags_out to zero.
- R13: Select-increment with zero operands and the inverted condition yields 1 or 0. Select-invert with zero operands and the inverted condition yields all ones or 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_sel | input | 3 | Operation select |
| wide | input | 1 | 1 = 64-bit, 0 = 32-bit |
| cond | input | 4 | Condition code |
| flags_in | input | 4 | Current NZCV |
| opa | input | 64 | First operand |
| opb | input | 64 | Second operand |
| imm5 | input | 5 | Unsigned compare immediate |
| use_imm | input | 1 | Compare uses imm5 instead of opb |
| fallback | input | 4 | NZCV loaded when a compare's condition fails |
| result | output | 64 | Registered result |
| flags_out | output | 4 | Registered next NZCV |

## Verification
A wrong condition decode shows up one cycle later, either as the wrong operand on result or as computed flags appearing where the fallback nibble should be. Because of that, every condition code is swept against every flag pattern through the plain select. Errors in carry or overflow appear only at the sign and carry boundaries of the chosen width. The compare vectors therefore sit exactly on the 64-bit and 32-bit wrap points, where a width slip changes flags_out in the very next cycle.

// File: rtl/cond_sel_pkg.sv
package cond_sel_pkg;
  localparam int FLAG_W = 4;
  localparam int FLG_N  = 3;
  localparam int FLG_Z  = 2;
  localparam int FLG_C  = 1;
  localparam int FLG_V  = 0;

  typedef enum logic [2:0] {
    OP_SEL  = 3'd0,
    OP_SINC = 3'd1,
    OP_SINV = 3'd2,
    OP_SNEG = 3'd3,
    OP_CMP  = 3'd4,
    OP_CMN  = 3'd5
  } csu_op_e;

  // Condition test against packed NZCV (R1)
  function automatic logic cond_holds(input logic [3:0] cc, input logic [FLAG_W-1:0] f);
    logic n, z, c, v;
    n = f[FLG_N]; z = f[FLG_Z]; c = f[FLG_C]; v = f[FLG_V];
    case (cc)
      4'h0: cond_holds = z;
      4'h1: cond_holds = !z;
      4'h2: cond_holds = c;
      4'h3: cond_holds = !c;
      4'h4: cond_holds = n;
      4'h5: cond_holds = !n;
      4'h6: cond_holds = v;
      4'h7: cond_holds = !v;
      4'h8: cond_holds = c && !z;
      4'h9: cond_holds = !c || z;
      4'hA: cond_holds = (n == v);
      4'hB: cond_holds = (n != v);
      4'hC: cond_holds = !z && (n == v);
      4'hD: cond_holds = z || (n != v);
      default: cond_holds = 1'b1;
    endcase
  endfunction

  function automatic logic is_compare(input logic [2:0] op);
    is_compare = (op == OP_CMP) || (op == OP_CMN);
  endfunction
endpackage

// File: rtl/csu_cond_eval.sv
module csu_cond_eval
  import cond_sel_pkg::*;
(
  input  logic [3:0]        cond,
  input  logic [FLAG_W-1:0] flags_in,
  output logic              cond_hold
);
  always_comb cond_hold = cond_holds(cond, flags_in);
endmodule

// File: rtl/csu_select_path.sv
module csu_select_path
  import cond_sel_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic [2:0]        op_sel,
  input  logic              wide,
  input  logic              cond_hold,
  input  logic [DATA_W-1:0] opa,
  input  logic [DATA_W-1:0] opb,
  output logic [DATA_W-1:0] sel_res
);
  localparam int HALF_W = DATA_W / 2;
  localparam logic [DATA_W-1:0] ONE = {{(DATA_W-1){1'b0}}, 1'b1};

  function automatic logic [DATA_W-1:0] alt_value(input logic [2:0] op, input logic [DATA_W-1:0] b);
    case (op)
      OP_SINC: alt_value = b + ONE;
      OP_SINV: alt_value = ~b;
      OP_SNEG: alt_value = ~b + ONE;
      default: alt_value = b;
    endcase
  endfunction

  logic [DATA_W-1:0] raw;
  logic [DATA_W-1:0] width_mask;

  always_comb begin
    raw        = cond_hold ? opa : alt_value(op_sel, opb);
    width_mask = wide ? {DATA_W{1'b1}} : {{(DATA_W-HALF_W){1'b0}}, {HALF_W{1'b1}}};
    sel_res    = raw & width_mask;
  end
endmodule

// File: rtl/csu_compare_path.sv
module csu_compare_path
  import cond_sel_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int IMM_W  = 5
) (
  input  logic              add_mode,
  input  logic              wide,
  input  logic              cond_hold,
  input  logic              use_imm,
  input  logic [IMM_W-1:0]  imm5,
  input  logic [DATA_W-1:0] opa,
  input  logic [DATA_W-1:0] opb,
  input  logic [FLAG_W-1:0] fallback,
  output logic [FLAG_W-1:0] cmp_flags
);
  localparam int HALF_W = DATA_W / 2;

  logic [DATA_W-1:0] b_sel, b_op;
  logic              cin;
  logic [DATA_W:0]   sum_w;
  logic [HALF_W:0]   sum_n;
  logic [FLAG_W-1:0] flg_w, flg_n;

  function automatic logic [FLAG_W-1:0] pack_flags(input logic sgn, input logic zro,
                                                   input logic cry, input logic ovf);
    logic [FLAG_W-1:0] f;
    f = '0;
    f[FLG_N] = sgn; f[FLG_Z] = zro; f[FLG_C] = cry; f[FLG_V] = ovf;
    pack_flags = f;
  endfunction

  always_comb begin
    b_sel = use_imm ? {{(DATA_W-IMM_W){1'b0}}, imm5} : opb;
    b_op  = add_mode ? b_sel : ~b_sel;
    cin   = !add_mode;
    sum_w = {1'b0, opa} + {1'b0, b_op} + {{DATA_W{1'b0}}, cin};
    sum_n = {1'b0, opa[HALF_W-1:0]} + {1'b0, b_op[HALF_W-1:0]} + {{HALF_W{1'b0}}, cin};
    flg_w = pack_flags(sum_w[DATA_W-1], sum_w[DATA_W-1:0] == '0, sum_w[DATA_W],
                       (opa[DATA_W-1] == b_op[DATA_W-1]) && (sum_w[DATA_W-1] != opa[DATA_W-1]));
    flg_n = pack_flags(sum_n[HALF_W-1], sum_n[HALF_W-1:0] == '0, sum_n[HALF_W],
                       (opa[HALF_W-1] == b_op[HALF_W-1]) && (sum_n[HALF_W-1] != opa[HALF_W-1]));
    cmp_flags = !cond_hold ? fallback : (wide ? flg_w : flg_n);
  end
endmodule

// File: rtl/cond_sel_unit.sv
module cond_sel_unit
  import cond_sel_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int IMM_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        op_sel,
  input  logic              wide,
  input  logic [3:0]        cond,
  input  logic [3:0]        flags_in,
  input  logic [DATA_W-1:0] opa,
  input  logic [DATA_W-1:0] opb,
  input  logic [IMM_W-1:0]  imm5,
  input  logic              use_imm,
  input  logic [3:0]        fallback,
  output logic [DATA_W-1:0] result,
  output logic [3:0]        flags_out
);
  logic              cond_hold;
  logic              is_cmp;
  logic [DATA_W-1:0] sel_res, res_d;
  logic [FLAG_W-1:0] cmp_flags, flg_d;

  csu_cond_eval u_cond (
    .cond      (cond),
    .flags_in  (flags_in),
    .cond_hold (cond_hold)
  );

  csu_select_path #(.DATA_W(DATA_W)) u_sel (
    .op_sel    (op_sel),
    .wide      (wide),
    .cond_hold (cond_hold),
    .opa       (opa),
    .opb       (opb),
    .sel_res   (sel_res)
  );

  csu_compare_path #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_cmp (
    .add_mode  (op_sel == OP_CMN),
    .wide      (wide),
    .cond_hold (cond_hold),
    .use_imm   (use_imm),
    .imm5      (imm5),
    .opa       (opa),
    .opb       (opb),
    .fallback  (fallback),
    .cmp_flags (cmp_flags)
  );

  always_comb begin
    is_cmp = is_compare(op_sel);
    res_d  = is_cmp ? '0 : sel_res;
    flg_d  = is_cmp ? cmp_flags : flags_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result    <= '0;
      flags_out <= '0;
    end else begin
      result    <= res_d;
      flags_out <= flg_d;
    end
  end
endmodule

// File: rtl/cond_sel_unit_chk.sv
module cond_sel_unit_chk #(
  parameter int DATA_W = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic [2:0]        op_sel,
  input logic              wide,
  input logic [3:0]        cond,
  input logic [3:0]        flags_in,
  input logic [DATA_W-1:0] opa,
  input logic [DATA_W-1:0] opb,
  input logic [3:0]        fallback,
  input logic [DATA_W-1:0] result,
  input logic [3:0]        flags_out,
  input logic              cond_hold
);
  localparam int HALF_W = DATA_W / 2;
  localparam logic [DATA_W-1:0] ONE = {{(DATA_W-1){1'b0}}, 1'b1};

  logic primed;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) primed <= 1'b0;
    else        primed <= 1'b1;
  end

  p_always_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (cond[3:1] == 3'b111) |-> cond_hold);

  p_sel_take_a_r2: assert property (@(posedge clk) disable iff (!rst_n)
    primed && $past(op_sel == 3'd0 && cond_hold && wide) |-> result == $past(opa));

  p_inc_fallback_r3: assert property (@(posedge clk) disable iff (!rst_n)
    primed && $past(op_sel == 3'd1 && !cond_hold && wide) |-> result == $past(opb) + ONE);

  p_cmp_fallback_r8: assert property (@(posedge clk) disable iff (!rst_n)
    primed && $past(op_sel[2:1] == 2'b10 && !cond_hold) |-> flags_out == $past(fallback));

  p_flags_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    primed && $past(op_sel[2:1] != 2'b10) |-> flags_out == $past(flags_in));

  p_cmp_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    primed && $past(op_sel[2:1] == 2'b10) |-> result == '0);

  p_upper_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    primed && $past(!wide) |-> result[DATA_W-1:HALF_W] == '0);
endmodule

bind cond_sel_unit cond_sel_unit_chk #(.DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .op_sel    (op_sel),
  .wide      (wide),
  .cond      (cond),
  .flags_in  (flags_in),
  .opa       (opa),
  .opb       (opb),
  .fallback  (fallback),
  .result    (result),
  .flags_out (flags_out),
  .cond_hold (cond_hold)
);

// File: tb/cond_sel_unit_bench.sv
module cond_sel_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  op_sel = '0;
  logic        wide = 1'b1;
  logic [3:0]  cond = '0;
  logic [3:0]  flags_in = '0;
  logic [63:0] opa = '0;
  logic [63:0] opb = '0;
  logic [4:0]  imm5 = '0;
  logic        use_imm = 1'b0;
  logic [3:0]  fallback = '0;
  logic [63:0] result;
  logic [3:0]  flags_out;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  cond_sel_unit u_cond_sel_unit (
    .clk(clk), .rst_n(rst_n), .op_sel(op_sel), .wide(wide), .cond(cond),
    .flags_in(flags_in), .opa(opa), .opb(opb), .imm5(imm5), .use_imm(use_imm),
    .fallback(fallback), .result(result), .flags_out(flags_out)
  );

  typedef struct packed {
    logic [2:0]  op;
    logic        wd;
    logic [3:0]  cc;
    logic [3:0]  fl;
    logic [63:0] a;
    logic [63:0] b;
    logic [4:0]  im;
    logic        ui;
    logic [3:0]  fb;
    logic [63:0] er;
    logic [3:0]  ef;
  } vec_t;

  localparam int NV = 23;
  localparam vec_t VEC [NV] = '{
    // R2 plain select, taken / not taken
    '{3'd0,1'b1,4'h0,4'h4,64'h1111,64'h2222,5'd0,1'b0,4'h0,64'h1111,4'h4},
    '{3'd0,1'b1,4'h0,4'h0,64'h1111,64'h2222,5'd0,1'b0,4'h0,64'h2222,4'h0},
    // R3 increment wraps to zero
    '{3'd1,1'b1,4'h1,4'h4,64'h0,64'hFFFF_FFFF_FFFF_FFFF,5'd0,1'b0,4'h0,64'h0,4'h4},
    // R4 invert
    '{3'd2,1'b1,4'h2,4'h0,64'h0,64'hFF,5'd0,1'b0,4'h0,64'hFFFF_FFFF_FFFF_FF00,4'h0},
    // R5 negate, then taken
    '{3'd3,1'b1,4'h4,4'h0,64'h0,64'h5,5'd0,1'b0,4'h0,64'hFFFF_FFFF_FFFF_FFFB,4'h0},
    '{3'd3,1'b1,4'h4,4'h8,64'h77,64'h5,5'd0,1'b0,4'h0,64'h77,4'h8},
    // R6 compare: equal, immediate borrow, signed overflow
    '{3'd4,1'b1,4'hE,4'h0,64'h5,64'h5,5'd0,1'b0,4'h0,64'h0,4'h6},
    '{3'd4,1'b1,4'hA,4'h9,64'h3,64'h0,5'd7,1'b1,4'h0,64'h0,4'h8},
    '{3'd4,1'b1,4'hE,4'h0,64'h8000_0000_0000_0000,64'h1,5'd0,1'b0,4'h0,64'h0,4'h3},
    // R7 compare-negative: carry to zero, overflow
    '{3'd5,1'b1,4'hE,4'h0,64'hFFFF_FFFF_FFFF_FFFF,64'h1,5'd0,1'b0,4'h0,64'h0,4'h6},
    '{3'd5,1'b1,4'hE,4'h0,64'h7FFF_FFFF_FFFF_FFFF,64'h1,5'd0,1'b0,4'h0,64'h0,4'h9},
    // R8 fallback nibble
    '{3'd4,1'b1,4'h0,4'h0,64'h5,64'h5,5'd0,1'b0,4'hA,64'h0,4'hA},
    '{3'd5,1'b1,4'h6,4'h0,64'h5,64'h5,5'd0,1'b0,4'h5,64'h0,4'h5},
    // R10 32-bit mode
    '{3'd0,1'b0,4'hE,4'h0,64'hDEAD_BEEF_1234_5678,64'h0,5'd0,1'b0,4'h0,64'h1234_5678,4'h0},
    '{3'd1,1'b0,4'h0,4'h0,64'h0,64'h1_FFFF_FFFF,5'd0,1'b0,4'h0,64'h0,4'h0},
    '{3'd4,1'b0,4'hE,4'h0,64'h8000_0000,64'h1,5'd0,1'b0,4'h0,64'h0,4'h3},
    '{3'd5,1'b0,4'hE,4'h0,64'hFFFF_FFFF,64'h1,5'd0,1'b0,4'h0,64'h0,4'h6},
    // R11 spare codes act as select
    '{3'd6,1'b1,4'hE,4'hF,64'hAB,64'h0,5'd0,1'b0,4'h0,64'hAB,4'hF},
    '{3'd7,1'b1,4'h0,4'h0,64'h0,64'hCD,5'd0,1'b0,4'h0,64'hCD,4'h0},
    // R13 set-on-condition and set-mask
    '{3'd1,1'b1,4'h1,4'h4,64'h0,64'h0,5'd0,1'b0,4'h0,64'h1,4'h4},
    '{3'd2,1'b1,4'h1,4'h0,64'h0,64'h0,5'd0,1'b0,4'h0,64'h0,4'h0},
    '{3'd2,1'b1,4'h1,4'h4,64'h0,64'h0,5'd0,1'b0,4'h0,64'hFFFF_FFFF_FFFF_FFFF,4'h4},
    // R7 compare-negative with immediate
    '{3'd5,1'b1,4'hE,4'h0,64'h10,64'h0,5'd3,1'b1,4'h0,64'h0,4'h0}
  };

  function automatic logic ref_cond(input logic [3:0] c, input logic [3:0] f);
    logic base;
    case (c[3:1])
      3'd0: base = f[2];
      3'd1: base = f[1];
      3'd2: base = f[3];
      3'd3: base = f[0];
      3'd4: base = f[1] & ~f[2];
      3'd5: base = (f[3] ~^ f[0]);
      3'd6: base = (f[3] ~^ f[0]) & ~f[2];
      default: base = 1'b1;
    endcase
    ref_cond = (c[3:1] != 3'd7 && c[0]) ? ~base : base;
  endfunction

  task automatic check(input logic [63:0] er, input logic [3:0] ef, input string tag);
    checks++;
    if (result !== er || flags_out !== ef) begin
      errors++;
      $display("FAIL %s result=%h flags=%h expected result=%h flags=%h", tag, result, flags_out, er, ef);
    end
  endtask

  task automatic apply(input vec_t v);
    @(negedge clk);
    op_sel = v.op; wide = v.wd; cond = v.cc; flags_in = v.fl; opa = v.a; opb = v.b;
    imm5 = v.im; use_imm = v.ui; fallback = v.fb;
    @(negedge clk);
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(64'h0, 4'h0, "R12 reset state");
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      apply(VEC[i]);
      check(VEC[i].er, VEC[i].ef, $sformatf("vector %0d (R2..R13)", i));
    end

    // R1 full condition sweep through plain select
    for (int c = 0; c < 16; c++) begin
      for (int f = 0; f < 16; f++) begin
        vec_t v;
        v = '0;
        v.op = 3'd0; v.wd = 1'b1; v.cc = 4'(c); v.fl = 4'(f);
        v.a = 64'h1; v.b = 64'h0;
        apply(v);
        check({63'h0, ref_cond(4'(c), 4'(f))}, 4'(f), $sformatf("R1 cond %0d flags %0h", c, f));
      end
    end

    // R12 one-cycle latency: output changes one edge after input
    begin
      vec_t v;
      v = '0;
      v.op = 3'd0; v.wd = 1'b1; v.cc = 4'hE; v.fl = 4'h0; v.a = 64'h55; v.b = 64'h0;
      apply(v);
      @(negedge clk);
      opa = 64'h66;
      @(posedge clk); #1;
      check(64'h66, 4'h0, "R12 latency");
    end

    // R12 reset mid-run clears outputs
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check(64'h0, 4'h0, "R12 async reset");
    @(negedge clk);
    rst_n = 1'b1;

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule